// File: doc/BRIEF.md
# RV32 Next-PC and Control-Transfer Unit

This block works out where an RV32 core fetches next, and what a jump writes back to its destination register. Each cycle it takes the current program counter, the instruction word and the two source register values. On the next clock edge it presents four results:

- the next program counter;
- a flag that says a control transfer happened;
- a write enable for the link register;
- the link value.

The block decodes the scattered immediate fields of conditional branches and jumps itself, so the caller passes the raw instruction word. Instruction fetch, flushing and prediction belong to the surrounding pipeline.

The unit covers four cases:

- Ordinary sequential flow.
- The six conditional branches, compared either signed or unsigned.
- The PC-relative jump.
- The register-relative jump, whose 12-bit offset is not scaled and whose target has bit 0 cleared.

If the branch condition code is not one of the six defined codes, the branch is not taken and an error flag is raised.

All outputs are registered. A result appears one clock after its inputs are presented, and a synchronous active-high reset clears every output.

Top module: `ctl_next_pc`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output becomes zero at that edge, whatever the inputs are.
- R2: An instruction whose opcode (bits [6:0]) is not 1100011, 1101111 or 1100111 produces `next_pc_o` = PC+4, with `taken_o`, `link_we_o` and `illegal_o` all 0.
- R3: Opcode 1100011 with condition field (bits [14:12]) 000 branches when rs1 equals rs2, and with condition field 001 it branches when they differ.
- R4: Condition field 100 branches when rs1 < rs2 as signed two's-complement numbers, and condition field 101 branches when rs1 >= rs2 under the same signed comparison.
- R5: Condition field 110 branches when rs1 < rs2 as unsigned numbers, and condition field 111 branches when rs1 >= rs2 under the same unsigned comparison.
- R6: A taken branch goes to PC plus a sign-extended 13-bit offset whose bit 0 is zero. The offset is built as follows: instruction bit 31 gives offset bit 12, bit 7 gives offset bit 11, bits [30:25] give offset bits [10:5], and bits [11:8] give offset bits [4:1]. A branch that is not taken goes to PC+4 with `taken_o` = 0. The addition wraps modulo 2^32.
- R7: A branch with condition field 010 or 011 is not taken: `next_pc_o` = PC+4, `taken_o` = 0, and `illegal_o` = 1.
- R8: Opcode 1101111 goes to PC plus a sign-extended 21-bit offset whose bit 0 is zero. The offset is built as follows: instruction bit 31 gives offset bit 20, bits [19:12] give offset bits [19:12], bit 20 gives offset bit 11, and bits [30:21] give offset bits [10:1]. The result also sets `taken_o` = 1 and `link_we_o` = 1.
- R9: Opcode 1100111 goes to rs1 plus the sign-extended instruction bits [31:20], with bit 0 of the sum forced to 0. The result also sets `taken_o` = 1 and `link_we_o` = 1.
- R10: `link_o` always equals PC+4 of the instruction presented one cycle earlier.
- R11: Outputs change only at rising clock edges, one cycle after their inputs are presented, and hold their value between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Control transfer happened |
| link_we_o | output | 1 | Write the link value to the destination register |
| link_o | output | 32 | Return address, PC+4 |
| illegal_o | output | 1 | Branch with an undefined condition code |

## Verification
A jump produces two results in the same cycle: a computed target on `next_pc_o` and the return address on `link_o`. Both are derived from the same PC but through different adders. The bench drives both jump kinds with extreme offsets, and a register-relative jump whose sum is odd, then compares the target and the link value independently against values it builds from its own immediate encoder. A second collision is a branch target that wraps past the top of the address space, checked in the same cycle as the link value.

// File: rtl/ctl_next_pc_pkg.sv
package ctl_next_pc_pkg;

  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    CND_EQ  = 3'b000,
    CND_NE  = 3'b001,
    CND_R2  = 3'b010,
    CND_R3  = 3'b011,
    CND_LT  = 3'b100,
    CND_GE  = 3'b101,
    CND_LTU = 3'b110,
    CND_GEU = 3'b111
  } cond_e;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BR,
    FLOW_JAL,
    FLOW_JALR
  } flow_e;

  function automatic flow_e classify(input logic [6:0] opc);
    case (opc)
      OPC_BRANCH: return FLOW_BR;
      OPC_JAL:    return FLOW_JAL;
      OPC_JALR:   return FLOW_JALR;
      default:    return FLOW_SEQ;
    endcase
  endfunction

endpackage

// File: rtl/ctl_imm_unpack.sv
module ctl_imm_unpack #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] jal_off,
  output logic [XLEN-1:0] reg_off
);
  localparam int BR_W  = 13;
  localparam int JAL_W = 21;
  localparam int REG_W = 12;

  logic [BR_W-1:0]  br_raw;
  logic [JAL_W-1:0] jal_raw;
  logic [REG_W-1:0] reg_raw;

  always_comb begin
    br_raw  = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    jal_raw = {instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
    reg_raw = instr[31:20];
    br_off  = {{(XLEN-BR_W){br_raw[BR_W-1]}}, br_raw};
    jal_off = {{(XLEN-JAL_W){jal_raw[JAL_W-1]}}, jal_raw};
    reg_off = {{(XLEN-REG_W){reg_raw[REG_W-1]}}, reg_raw};
  end
endmodule

// File: rtl/ctl_branch_cmp.sv
module ctl_branch_cmp
  import ctl_next_pc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      cond,
  output logic            take,
  output logic            bad
);
  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (a == b);
    lt_s = ($signed(a) < $signed(b));
    lt_u = (a < b);
    take = 1'b0;
    bad  = 1'b0;
    case (cond_e'(cond))
      CND_EQ:  take = eq;
      CND_NE:  take = !eq;
      CND_LT:  take = lt_s;
      CND_GE:  take = !lt_s;
      CND_LTU: take = lt_u;
      CND_GEU: take = !lt_u;
      default: bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc
  import ctl_next_pc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_o,
  output logic            illegal_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] br_off, jal_off, reg_off;
  logic            cmp_take, cmp_bad;
  flow_e           flow;
  logic [XLEN-1:0] seq_pc, rel_base, rel_off, rel_sum, reg_sum;
  logic [XLEN-1:0] nxt_d;
  logic            tk_d, we_d, ill_d;

  ctl_imm_unpack #(.XLEN(XLEN)) u_imm (
    .instr   (instr_i),
    .br_off  (br_off),
    .jal_off (jal_off),
    .reg_off (reg_off)
  );

  ctl_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .a    (rs1_i),
    .b    (rs2_i),
    .cond (instr_i[14:12]),
    .take (cmp_take),
    .bad  (cmp_bad)
  );

  always_comb begin
    flow     = classify(instr_i[6:0]);
    seq_pc   = pc_i + STEP;
    rel_base = pc_i;
    rel_off  = (flow == FLOW_JAL) ? jal_off : br_off;
    rel_sum  = rel_base + rel_off;
    reg_sum  = rs1_i + reg_off;
    nxt_d    = seq_pc;
    tk_d     = 1'b0;
    we_d     = 1'b0;
    ill_d    = 1'b0;
    case (flow)
      FLOW_BR: begin
        ill_d = cmp_bad;
        tk_d  = cmp_take;
        if (cmp_take) nxt_d = rel_sum;
      end
      FLOW_JAL: begin
        tk_d  = 1'b1;
        we_d  = 1'b1;
        nxt_d = rel_sum;
      end
      FLOW_JALR: begin
        tk_d  = 1'b1;
        we_d  = 1'b1;
        nxt_d = {reg_sum[XLEN-1:1], 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o <= '0;
      taken_o   <= 1'b0;
      link_we_o <= 1'b0;
      link_o    <= '0;
      illegal_o <= 1'b0;
    end else begin
      next_pc_o <= nxt_d;
      taken_o   <= tk_d;
      link_we_o <= we_d;
      link_o    <= seq_pc;
      illegal_o <= ill_d;
    end
  end
endmodule

// File: rtl/ctl_next_pc_chk.sv
module ctl_next_pc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] rs1_i,
  input logic [XLEN-1:0] rs2_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_o,
  input logic            illegal_o
);
  logic is_br, is_jal, is_jalr;
  assign is_br   = (instr_i[6:0] == 7'b1100011);
  assign is_jal  = (instr_i[6:0] == 7'b1101111);
  assign is_jalr = (instr_i[6:0] == 7'b1100111);

  AST_LINK_IS_PC4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> link_o == $past(pc_i) + XLEN'(4)); // R10

  AST_SEQ_FLOW: assert property (@(posedge clk) disable iff (rst)
    (!is_br && !is_jal && !is_jalr) |=>
      (next_pc_o == $past(pc_i) + XLEN'(4)) && !taken_o && !link_we_o && !illegal_o); // R2

  AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    is_br |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(4)) && !link_we_o); // R6

  AST_REGJUMP_EVEN: assert property (@(posedge clk) disable iff (rst)
    is_jalr |=> !next_pc_o[0] && taken_o && link_we_o); // R9

  AST_JAL_LINKS: assert property (@(posedge clk) disable iff (rst)
    is_jal |=> taken_o && link_we_o && !illegal_o); // R8

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> !taken_o && !link_we_o); // R7
endmodule

bind ctl_next_pc ctl_next_pc_chk #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_ctl_next_pc.sv
module test_ctl_next_pc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0, instr_i = '0, rs1_i = '0, rs2_i = '0;
  logic [31:0] next_pc_o, link_o;
  logic        taken_o, link_we_o, illegal_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ctl_next_pc i_ctl_next_pc (
    .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .link_we_o(link_we_o), .link_o(link_o),
    .illegal_o(illegal_o)
  );

  // sel: 0 plain ALU op, 1 branch, 2 pc-relative jump, 3 register jump
  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  f3;
    logic [31:0] off;
    logic [31:0] pc;
    logic [31:0] a;
    logic [31:0] b;
    logic        tk;
    logic        il;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 32'h0000_0010, 32'h0000_0100, 32'h1, 32'h2, 1'b0, 1'b0}, // R2
    '{2'd1, 3'd0, 32'h0000_0018, 32'h0000_1000, 32'h5, 32'h5, 1'b1, 1'b0}, // R3 beq eq
    '{2'd1, 3'd0, 32'h0000_0018, 32'h0000_1000, 32'h5, 32'h6, 1'b0, 1'b0}, // R3 beq ne
    '{2'd1, 3'd1, 32'hFFFF_FFF8, 32'h0000_1000, 32'h5, 32'h6, 1'b1, 1'b0}, // R3 bne
    '{2'd1, 3'd4, 32'h0000_0040, 32'h0000_0800, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b0}, // R4 blt
    '{2'd1, 3'd6, 32'h0000_0040, 32'h0000_0800, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0}, // R5 bltu
    '{2'd1, 3'd5, 32'hFFFF_F000, 32'h0000_2000, 32'h1, 32'hFFFF_FFFF, 1'b1, 1'b0}, // R4 bge min off
    '{2'd1, 3'd7, 32'hFFFF_F000, 32'h0000_2000, 32'h1, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R5 bgeu
    '{2'd1, 3'd5, 32'h0000_0FFE, 32'h0000_2000, 32'h7, 32'h7, 1'b1, 1'b0}, // R4 bge eq max off
    '{2'd1, 3'd6, 32'h0000_0100, 32'h0000_3000, 32'h0, 32'h8000_0000, 1'b1, 1'b0}, // R5 bltu
    '{2'd1, 3'd2, 32'h0000_0100, 32'h0000_3000, 32'h3, 32'h3, 1'b0, 1'b1}, // R7
    '{2'd1, 3'd3, 32'h0000_0100, 32'h0000_3000, 32'h3, 32'h4, 1'b0, 1'b1}, // R7
    '{2'd2, 3'd0, 32'h000F_FFFE, 32'h0001_0000, 32'h0, 32'h0, 1'b1, 1'b0}, // R8 max
    '{2'd2, 3'd0, 32'hFFF0_0000, 32'h0020_0000, 32'h0, 32'h0, 1'b1, 1'b0}, // R8 min
    '{2'd3, 3'd0, 32'hFFFF_FFFE, 32'h0000_5000, 32'h3001, 32'h0, 1'b1, 1'b0}, // R9 odd sum
    '{2'd3, 3'd0, 32'h0000_07FF, 32'h0000_5000, 32'h4000, 32'h0, 1'b1, 1'b0}, // R9
    '{2'd1, 3'd1, 32'h0000_0020, 32'hFFFF_FFF0, 32'h1, 32'h2, 1'b1, 1'b0}  // R6 wrap
  };

  function automatic logic [31:0] encode(vec_t v);
    logic [31:0] o;
    o = v.off;
    case (v.sel)
      2'd1: return {o[12], o[10:5], 5'd2, 5'd1, v.f3, o[4:1], o[11], 7'b1100011};
      2'd2: return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
      2'd3: return {o[11:0], 5'd1, 3'b000, 5'd1, 7'b1100111};
      default: return {o[11:0], 5'd1, 3'b000, 5'd1, 7'b0010011};
    endcase
  endfunction

  function automatic logic [31:0] expect_pc(vec_t v);
    case (v.sel)
      2'd1: return v.tk ? v.pc + v.off : v.pc + 32'd4;
      2'd2: return v.pc + v.off;
      2'd3: return (v.a + v.off) & 32'hFFFF_FFFE;
      default: return v.pc + 32'd4;
    endcase
  endfunction

  function automatic string tag(vec_t v);
    if (v.sel == 2'd0) return "R2";
    if (v.sel == 2'd2) return "R8";
    if (v.sel == 2'd3) return "R9";
    case (v.f3)
      3'd0, 3'd1: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6, 3'd7: return "R5";
      default:    return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_zero(string req);
    chk(req, next_pc_o, 32'h0);
    chk(req, {31'h0, taken_o}, 32'h0);
    chk(req, {31'h0, link_we_o}, 32'h0);
    chk(req, link_o, 32'h0);
    chk(req, {31'h0, illegal_o}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] prev_pc;
    prev_pc = '0;
    // reset state, R1
    repeat (3) @(posedge clk);
    #1 chk_zero("R1");
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pc_i    = VECS[i].pc;
      instr_i = encode(VECS[i]);
      rs1_i   = VECS[i].a;
      rs2_i   = VECS[i].b;
      #1;
      if (i > 0) chk("R11", next_pc_o, prev_pc); // held until the edge
      @(posedge clk);
      #1;
      chk({tag(VECS[i]), " next"}, next_pc_o, expect_pc(VECS[i]));
      if (VECS[i].sel == 2'd1) chk("R6 target", next_pc_o, expect_pc(VECS[i]));
      chk({tag(VECS[i]), " taken"}, {31'h0, taken_o}, {31'h0, VECS[i].tk});
      chk({tag(VECS[i]), " link_we"}, {31'h0, link_we_o}, {31'h0, VECS[i].sel[1]});
      chk("R10", link_o, VECS[i].pc + 32'd4);
      chk({tag(VECS[i]), " illegal"}, {31'h0, illegal_o}, {31'h0, VECS[i].il});
      prev_pc = expect_pc(VECS[i]);
    end

    // R1: reset wins over a jump presented in the same cycle
    @(negedge clk);
    rst     = 1'b1;
    pc_i    = 32'h0000_7000;
    instr_i = encode('{2'd2, 3'd0, 32'h0000_0100, 32'h0000_7000, 32'h0, 32'h0, 1'b1, 1'b0});
    @(posedge clk);
    #1 chk_zero("R1");
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1 chk("R8 after reset", next_pc_o, 32'h0000_7100);
    chk("R10 after reset", link_o, 32'h0000_7004);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule